// File: doc/BRIEF.md
# Per-Lane Receive Error Counter

This block keeps a running error tally for every lane of a multi-lane 8b/10b serial receiver. Each clock, each lane hands over a group of decoded characters. Each character comes with three things: a running-disparity fault flag, a flag that the code group was not a valid code, and a control-code flag together with the 8-bit decoded value. The block sorts the faults into three classes. A per-class mask set by software can silence any of them. The number of characters that still carry a fault is added to a saturating counter for that lane. While a lane is still in code-group synchronization, its counter is frozen, because faults seen during alignment carry no meaning.

Software reaches the block through a simple word-addressed register port. One control word holds a clear bit and the three class masks. Each lane counter has its own read-only word, and these words repeat at a fixed stride. Reads return data one clock after the request. The decoder, the alignment logic and the bus bridge that drives the register port sit outside this block.

Top module: `lane_err_stats`

## Requirements
- R1: Each lane owns a counter of CNT_W bits (default 32). Lane n is read at byte address 0x308 + n*0x20. rd_data shows the addressed word on the clock after the edge that sampled rd_en, and holds its value while rd_en is low.
- R2: Each lane carries 4 characters per clock. On each edge the counter grows by the number of that lane's characters that carry at least one unmasked fault, so one character adds at most 1.
- R3: A counter at its all-ones value stays there and never wraps. No counter ever decreases unless it is cleared.
- R4: Setting control bit 8 stops disparity faults from being counted.
- R5: Setting control bit 9 stops invalid-code faults from being counted.
- R6: A character with the control flag set whose value bits [4:0] differ from 5'b11100 (K28) is an unexpected-control fault. K28 control characters are never faults. Setting control bit 10 stops this class from being counted.
- R7: While a lane's sync-phase input is high, that lane's counter does not change on that edge.
- R8: The control word is at byte address 0x244, and a write there takes effect from the next edge. While its bit 0 reads 1, all counters are held at zero. Counting resumes on the edge after the write that clears the bit.
- R9: After reset the control word and all counters are zero. A control read returns bit 0 and bits 10:8, with every other bit zero. Reads of unmapped addresses, or of a lane index at or above NUM_LANES, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_disp_err | input | NUM_LANES*CHARS | Disparity fault flag per character |
| ch_bad_code | input | NUM_LANES*CHARS | Invalid-code flag per character |
| ch_is_ctrl | input | NUM_LANES*CHARS | Control-code flag per character |
| ch_value | input | NUM_LANES*CHARS*8 | Decoded character values, 8 bits each |
| lane_syncing | input | NUM_LANES | Lane is in code-group synchronization |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench checks saturation on a second instance with 8-bit counters, which fills up in a few hundred clocks. A counter that wraps would then read back small values where the reference holds at 255. K28 control characters are mixed with other control values, so a classifier that flags every control code, or none, drifts away from the reference. The clear bit is held for several clocks and then released, so a design that only clears for one clock, or resumes a clock early or late, gives a counter that is off. Lane indices just past NUM_LANES, and addresses between the lane strides, are read back to make sure an address decoder that aliases them shows up.

// File: rtl/lerr_pkg.sv
package lerr_pkg;
  localparam logic [4:0] K28_LOW = 5'b11100;

  typedef struct packed {
    logic ctrl;
    logic bad;
    logic disp;
  } lerr_mask_t;

  function automatic logic unexpected_ctrl(input logic is_k, input logic [7:0] v);
    return is_k && (v[4:0] != K28_LOW);
  endfunction
endpackage

// File: rtl/lerr_lane_classify.sv
module lerr_lane_classify
  import lerr_pkg::*;
#(
  parameter int CHARS = 4,
  parameter int INC_W = $clog2(CHARS + 1)
) (
  input  logic [CHARS-1:0]   disp_err,
  input  logic [CHARS-1:0]   bad_code,
  input  logic [CHARS-1:0]   is_ctrl,
  input  logic [CHARS*8-1:0] value,
  input  lerr_mask_t         mask,
  output logic [INC_W-1:0]   inc
);
  logic [CHARS-1:0] hit;

  for (genvar c = 0; c < CHARS; c++) begin : g_char
    assign hit[c] = (disp_err[c] & ~mask.disp)
                  | (bad_code[c] & ~mask.bad)
                  | (unexpected_ctrl(is_ctrl[c], value[c*8 +: 8]) & ~mask.ctrl);
  end

  always_comb begin
    inc = '0;
    for (int c = 0; c < CHARS; c++) inc = inc + INC_W'(hit[c]);
  end

  always_comb begin
    assert ({28'd0, inc} <= CHARS) else $error("p_inc_bound_r2 violated");
  end
endmodule

// File: rtl/lerr_sat_counter.sv
module lerr_sat_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hold,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (!hold) cnt <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  p_sat_stick_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == '1) |=> (cnt == '1));
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt >= $past(cnt)));
  p_sync_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (hold && !clr) |=> $stable(cnt));
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/lerr_regs.sv
module lerr_regs
  import lerr_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int CTRL_ADDR  = 'h244,
  parameter int LANE_BASE  = 'h308,
  parameter int STRIDE_LG2 = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [NUM_LANES*CNT_W-1:0] cnt_flat,
  output logic                       clr,
  output lerr_mask_t                 mask,
  output logic [DATA_W-1:0]          rd_data
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(LANE_BASE);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] idx;
  logic              lane_hit;
  logic [DATA_W-1:0] rd_next;

  assign off      = rd_addr - BASE_A;
  assign idx      = off >> STRIDE_LG2;
  assign lane_hit = (rd_addr >= BASE_A) && (off[STRIDE_LG2-1:0] == '0)
                    && (idx < ADDR_W'(NUM_LANES));

  always_ff @(posedge clk) begin
    if (rst) begin
      clr  <= 1'b0;
      mask <= '0;
    end else if (wr_en && wr_addr == CTRL_A) begin
      clr  <= wr_data[0];
      mask <= lerr_mask_t'(wr_data[10:8]);
    end
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == CTRL_A) begin
      rd_next[0]    = clr;
      rd_next[10:8] = mask;
    end else if (lane_hit) begin
      for (int l = 0; l < NUM_LANES; l++)
        if (idx == ADDR_W'(l)) rd_next = DATA_W'(cnt_flat[l*CNT_W +: CNT_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  p_ctrl_spare_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == CTRL_A) |=> (rd_data[7:1] == '0 && rd_data[DATA_W-1:11] == '0));
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != CTRL_A && !lane_hit) |=> (rd_data == '0));
  p_read_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/lane_err_stats.sv
module lane_err_stats
  import lerr_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int CHARS      = 4,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int CTRL_ADDR  = 'h244,
  parameter int LANE_BASE  = 'h308,
  parameter int STRIDE_LG2 = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_LANES*CHARS-1:0]   ch_disp_err,
  input  logic [NUM_LANES*CHARS-1:0]   ch_bad_code,
  input  logic [NUM_LANES*CHARS-1:0]   ch_is_ctrl,
  input  logic [NUM_LANES*CHARS*8-1:0] ch_value,
  input  logic [NUM_LANES-1:0]         lane_syncing,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data
);
  localparam int INC_W = $clog2(CHARS + 1);

  logic [NUM_LANES*CNT_W-1:0] cnt_flat;
  logic                       clr;
  lerr_mask_t                 mask;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [INC_W-1:0] inc;

    lerr_lane_classify #(.CHARS(CHARS), .INC_W(INC_W)) u_cls (
      .disp_err (ch_disp_err[l*CHARS +: CHARS]),
      .bad_code (ch_bad_code[l*CHARS +: CHARS]),
      .is_ctrl  (ch_is_ctrl[l*CHARS +: CHARS]),
      .value    (ch_value[l*CHARS*8 +: CHARS*8]),
      .mask     (mask),
      .inc      (inc)
    );

    lerr_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .hold (lane_syncing[l]),
      .inc  (inc),
      .cnt  (cnt_flat[l*CNT_W +: CNT_W])
    );
  end

  lerr_regs #(
    .NUM_LANES(NUM_LANES), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .LANE_BASE(LANE_BASE), .STRIDE_LG2(STRIDE_LG2)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .cnt_flat (cnt_flat),
    .clr      (clr),
    .mask     (mask),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/tb_lane_err_stats.sv
module tb_lane_err_stats;
  localparam int NL = 4;
  localparam int CH = 4;
  localparam int NW = NL * CH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0]   disp = '0, bad = '0, isk = '0;
  logic [NW*8-1:0] val = '0;
  logic [NL-1:0]   sync = '0;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]     wr_addr = '0, rd_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [31:0]     rd_w, rd_n;

  always #2ns clk = ~clk;

  lane_err_stats dut (
    .clk(clk), .rst(rst), .ch_disp_err(disp), .ch_bad_code(bad), .ch_is_ctrl(isk),
    .ch_value(val), .lane_syncing(sync), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_w));

  lane_err_stats #(.CNT_W(8)) dut_n (
    .clk(clk), .rst(rst), .ch_disp_err(disp), .ch_bad_code(bad), .ch_is_ctrl(isk),
    .ch_value(val), .lane_syncing(sync), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_n));

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  string req = "R9";
  longint m_w[NL], m_n[NL];
  bit m_clr = 0;
  bit [2:0] m_mask = 0;
  logic [31:0] exp_w = 0, exp_n = 0;
  int pd = 0, pb = 0, pk = 0, ps = 0, pk28 = 50;

  function automatic logic [31:0] model_read(input logic [11:0] a, input bit narrow);
    int o;
    if (a == 12'h244) return {21'd0, m_mask, 7'd0, m_clr};
    o = int'(a) - 'h308;
    if (o >= 0 && o % 32 == 0 && o / 32 < NL)
      return narrow ? 32'(m_n[o/32]) : 32'(m_w[o/32]);
    return 0;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", req, tag, rd_addr, act, exp);
    end
  endtask

  task automatic tick();
    if (rst) begin
      exp_w = 0; exp_n = 0;
      foreach (m_w[l]) begin m_w[l] = 0; m_n[l] = 0; end
      m_clr = 0; m_mask = 0;
    end else begin
      if (rd_en) begin exp_w = model_read(rd_addr, 0); exp_n = model_read(rd_addr, 1); end
      for (int l = 0; l < NL; l++) begin
        int inc = 0;
        for (int c = 0; c < CH; c++) begin
          int i = l * CH + c;
          bit e = (disp[i] && !m_mask[0]) || (bad[i] && !m_mask[1]) ||
                  (isk[i] && val[i*8 +: 5] != 5'd28 && !m_mask[2]);
          if (e) inc++;
        end
        if (m_clr) begin m_w[l] = 0; m_n[l] = 0; end
        else if (!sync[l]) begin
          m_w[l] = (m_w[l] + inc > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : m_w[l] + inc;
          m_n[l] = (m_n[l] + inc > 255) ? 255 : m_n[l] + inc;
        end
      end
      if (wr_en && wr_addr == 12'h244) begin m_clr = wr_data[0]; m_mask = wr_data[10:8]; end
    end
    @(negedge clk);
    cyc++;
    check(rd_w, exp_w, "wide");
    check(rd_n, exp_n, "narrow");
  endtask

  task automatic stim();
    for (int i = 0; i < NW; i++) begin
      disp[i] = ($urandom_range(99) < pd);
      bad[i]  = ($urandom_range(99) < pb);
      isk[i]  = ($urandom_range(99) < pk);
      val[i*8 +: 8] = ($urandom_range(99) < pk28) ? {3'($urandom), 5'd28} : 8'($urandom);
    end
    for (int l = 0; l < NL; l++) sync[l] = ($urandom_range(99) < ps);
    rd_en = 1'b1;
    rd_addr = 12'(32'h308 + (cyc % NL) * 32);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin stim(); tick(); end
  endtask

  task automatic wr_ctrl(input logic [31:0] d);
    stim();
    wr_en = 1'b1; wr_addr = 12'h244; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R9: reset state
    req = "R9";
    rd_en = 1'b1; rd_addr = 12'h308;
    repeat (3) tick();
    rst = 1'b0;
    rd_addr = 12'h244; tick(); tick();
    rd_addr = 12'h328; tick(); tick();

    // R1 R2: unmasked mixed faults, all lanes read at stride
    req = "R1 R2"; pd = 15; pb = 15; pk = 20; run(400);

    // R4: disparity faults only, mask toggled
    req = "R4"; pd = 40; pb = 0; pk = 0;
    wr_ctrl(32'h1); wr_ctrl(32'h0); run(40);
    wr_ctrl(32'h100); run(60); wr_ctrl(32'h0); run(30);

    // R5: invalid-code faults only
    req = "R5"; pd = 0; pb = 40;
    wr_ctrl(32'h1); wr_ctrl(32'h0); run(40);
    wr_ctrl(32'h200); run(60); wr_ctrl(32'h0); run(30);

    // R6: control codes, K28 vs others
    req = "R6"; pb = 0; pk = 60; pk28 = 70;
    wr_ctrl(32'h1); wr_ctrl(32'h0); run(40);
    pk28 = 100; run(40);
    pk28 = 30; wr_ctrl(32'h400); run(50); wr_ctrl(32'h0); run(30);

    // R7: sync phase freezes counters
    req = "R7"; pd = 20; pb = 20; pk = 20; pk28 = 50;
    wr_ctrl(32'h1); wr_ctrl(32'h0);
    ps = 100; run(30); ps = 40; run(100); ps = 0;

    // R8: clear held, then released, with masks read back
    req = "R8"; run(20);
    wr_ctrl(32'h701); run(15);
    stim(); rd_addr = 12'h244; tick();
    wr_ctrl(32'h0); run(30);
    wr_ctrl(32'h1); wr_ctrl(32'h0); run(10);

    // R3: saturation on narrow instance, long heavy run
    req = "R3"; pd = 70; pb = 70; pk = 50; pk28 = 20; run(600);

    // R9: unmapped, out-of-range lanes, spare control bits
    req = "R9";
    for (int a = 0; a < 12; a++) begin
      stim();
      case (a % 6)
        0: rd_addr = 12'h388;
        1: rd_addr = 12'h3A8;
        2: rd_addr = 12'h30C;
        3: rd_addr = 12'h300;
        4: rd_addr = 12'h244;
        default: rd_addr = 12'h248;
      endcase
      tick();
    end
    wr_ctrl(32'hFFFF_FFFE);
    stim(); rd_addr = 12'h244; tick(); tick();
    // R1: read strobe low holds rd_data
    req = "R1"; stim(); rd_en = 1'b0; tick(); rd_en = 1'b0; tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule